// File: doc/BRIEF.md
# Pipeline issue interlock

This unit sits at the issue stage of an in-order integer pipeline. Each cycle it looks at up to two decoded candidates held by the fetch/decode logic: an older one in slot 0 and a younger one in slot 1. Each candidate carries an operation class, a destination register and two source registers. The unit decides which of them may leave the issue stage in this cycle. Upstream logic uses `issue_valid` to advance its queue. A slot that was not issued stays where it is and is presented again, so program order is kept.

The unit keeps a small amount of in-flight state. It records which registers were written by loads issued in the previous cycle, to enforce the load delay slot. It also runs a countdown for the non-pipelined multiplier, which is busy for `MUL_LAT` cycles after a multiply issues. For the candidate pair it reports flow, output and anti dependencies. Any of these stops the younger instruction from pairing with the older one.

A mode pin chooses how the unit reacts to a busy multiplier. In one setting it freezes all issue. In the other it holds only instructions that need the multiplier or touch its destination. A second pin chooses between single-issue and dual-issue.

Top module: `iil_issue_unit`

## Requirements
- R1: After reset is released, no load or multiply is treated as in flight, so the first valid candidate issues whatever registers it names.
- R2: ALU-class instructions (class code 1) never stall one another: an ALU candidate that reads the destination of the ALU issued in the previous cycle issues at once.
- R3: A candidate that reads the nonzero destination of a load (class code 2) is stalled if it is presented in the cycle right after the load issued. It stalls for exactly that one cycle and issues in the following cycle.
- R4: After a multiply (class code 5) issues in cycle t, neither another multiply nor an instruction that reads or writes the multiply's nonzero destination can issue before cycle t+MUL_LAT. With the mode pin low, such an instruction issues in cycle t+MUL_LAT (MUL_LAT = 3 by default).
- R5: With `mul_block_all` high, no candidate issues while a multiply is in progress (cycles t+1 to t+MUL_LAT-1). With it low, candidates unrelated to the multiplier issue during those cycles.
- R6: Register index 0 never produces a dependency bit or an interlock.
- R7: `dep_vec` bit 2 is flow (a slot 1 source equals the slot 0 destination), bit 1 is output (the two destinations are equal) and bit 0 is anti (the slot 1 destination equals a slot 0 source). The vector is 0 unless both slots are valid.
- R8: With `dual_mode` high, `issue_valid` is 2'b11 when slot 0 issues, slot 1 is valid and free of in-flight hazards, `dep_vec` is zero and the two candidates are not both multiplies. With `dual_mode` low, `issue_valid[1]` is always 0.
- R9: When a pair cannot issue together, slot 0 issues alone (`issue_valid` = 2'b01). `issue_valid[1]` is never set without `issue_valid[0]`.
- R10: A branch (class code 4) adds no stall and drops nothing. The candidate beside it or after it issues exactly as it would after an ALU instruction.
- R11: `stall` is 1 exactly when slot 0 is valid and not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dual_mode | input | 1 | 1 allows two candidates to issue per cycle |
| mul_block_all | input | 1 | 1 freezes all issue while the multiplier is busy |
| s0_valid | input | 1 | Slot 0 (older) candidate present |
| s0_cls | input | 3 | Slot 0 class: 0 none, 1 ALU, 2 load, 3 store, 4 branch, 5 multiply |
| s0_dst | input | RW | Slot 0 destination register, 0 for none |
| s0_srca | input | RW | Slot 0 first source register, 0 for none |
| s0_srcb | input | RW | Slot 0 second source register, 0 for none |
| s1_valid | input | 1 | Slot 1 (younger) candidate present |
| s1_cls | input | 3 | Slot 1 class, same encoding |
| s1_dst | input | RW | Slot 1 destination register |
| s1_srca | input | RW | Slot 1 first source register |
| s1_srcb | input | RW | Slot 1 second source register |
| issue_valid | output | 2 | Bit k set when slot k issues in this cycle |
| stall | output | 1 | Slot 0 is held in this cycle |
| dep_vec | output | 3 | {flow, output, anti} for the presented pair |

## Verification
The assertions check the cycle-invariant rules on every cycle. The younger slot never issues without the older one. Single mode never issues slot 1. A nonzero dependency vector always blocks pairing. A full freeze holds while the multiplier is busy in block-all mode. A load consumer is never issued in the shadow cycle. A restarted multiply is never accepted while one is running. Register 0 never interlocks. Other properties depend on timing and can only be shown by the bench's scenarios: the exact number of stall cycles after a multiply or a load, release at the right cycle, the arithmetic mapping of every register combination onto the three dependency bits, and the behaviour next to branches.

// File: rtl/iil_pkg.sv
package iil_pkg;

  localparam int ISSUE_W = 2;

  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_ALU    = 3'd1,
    CL_LOAD   = 3'd2,
    CL_STORE  = 3'd3,
    CL_BRANCH = 3'd4,
    CL_MUL    = 3'd5
  } iclass_e;

endpackage

// File: rtl/iil_rst_sync.sv
module iil_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/iil_slot_hazard.sv
module iil_slot_hazard
  import iil_pkg::*;
#(
  parameter int RW  = 5,
  parameter int NLD = 2
) (
  input  logic                    valid,
  input  iclass_e                 cls,
  input  logic [RW-1:0]           dst,
  input  logic [RW-1:0]           srca,
  input  logic [RW-1:0]           srcb,
  input  logic [NLD-1:0]          ld_v,
  input  logic [NLD-1:0][RW-1:0]  ld_dst,
  input  logic                    mul_busy,
  input  logic [RW-1:0]           mul_dst,
  input  logic                    block_all,
  output logic                    hazard
);

  logic ld_hit;
  logic mul_hit;
  logic freeze_hit;

  // Load shadow: a source matching a load issued one cycle earlier.
  always_comb begin
    ld_hit = 1'b0;
    for (int j = 0; j < NLD; j++) begin
      if (ld_v[j] && (ld_dst[j] != '0) &&
          ((srca == ld_dst[j]) || (srcb == ld_dst[j]))) begin
        ld_hit = 1'b1;
      end
    end
  end

  // Multiplier: structural conflict or any touch of its destination.
  always_comb begin
    mul_hit = 1'b0;
    if (mul_busy) begin
      if (cls == CL_MUL) begin
        mul_hit = 1'b1;
      end else if (mul_dst != '0) begin
        mul_hit = (srca == mul_dst) || (srcb == mul_dst) || (dst == mul_dst);
      end
    end
    freeze_hit = mul_busy && block_all;
  end

  assign hazard = valid && (ld_hit || mul_hit || freeze_hit);

endmodule

// File: rtl/iil_pair_dep.sv
module iil_pair_dep #(
  parameter int RW = 5
) (
  input  logic          v_old,
  input  logic [RW-1:0] d_old,
  input  logic [RW-1:0] a_old,
  input  logic [RW-1:0] b_old,
  input  logic          v_new,
  input  logic [RW-1:0] d_new,
  input  logic [RW-1:0] a_new,
  input  logic [RW-1:0] b_new,
  output logic [2:0]    dep
);

  logic both;
  logic raw;
  logic waw;
  logic war;

  always_comb begin
    both = v_old && v_new;
    raw  = (d_old != '0) && ((a_new == d_old) || (b_new == d_old));
    waw  = (d_old != '0) && (d_new == d_old);
    war  = (d_new != '0) && ((d_new == a_old) || (d_new == b_old));
    dep  = both ? {raw, waw, war} : 3'b000;
  end

endmodule

// File: rtl/iil_scoreboard.sv
module iil_scoreboard
  import iil_pkg::*;
#(
  parameter int RW      = 5,
  parameter int MUL_LAT = 3,
  localparam int CW     = (MUL_LAT > 2) ? $clog2(MUL_LAT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ISSUE_W-1:0]          iss,
  input  iclass_e                     cls [ISSUE_W],
  input  logic [ISSUE_W-1:0][RW-1:0]  dst,
  output logic [ISSUE_W-1:0]          ld_v,
  output logic [ISSUE_W-1:0][RW-1:0]  ld_dst,
  output logic                        mul_busy,
  output logic [RW-1:0]               mul_dst
);

  logic [CW-1:0]               cnt_q, cnt_d;
  logic [RW-1:0]               mdst_q, mdst_d;
  logic                        mdst_en;
  logic [ISSUE_W-1:0]          ldv_q, ldv_d;
  logic [ISSUE_W-1:0][RW-1:0]  ldd_q, ldd_d;
  logic [ISSUE_W-1:0]          mul_start;

  // Next state
  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      mul_start[k] = iss[k] && (cls[k] == CL_MUL);
      ldv_d[k]     = iss[k] && (cls[k] == CL_LOAD) && (dst[k] != '0);
      ldd_d[k]     = ldv_d[k] ? dst[k] : '0;
    end
    cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    mdst_en = |mul_start;
    mdst_d  = mul_start[0] ? dst[0] : dst[1];
    if (mdst_en) cnt_d = CW'(MUL_LAT - 1);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ldv_q <= '0;
      ldd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ldv_q <= ldv_d;
      ldd_q <= ldd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mdst_q <= '0;
    else if (mdst_en) mdst_q <= mdst_d;
  end

  assign ld_v     = ldv_q;
  assign ld_dst   = ldd_q;
  assign mul_busy = (cnt_q != '0);
  assign mul_dst  = mdst_q;

  // R4: the multiplier is never restarted while it is running
  p_no_mul_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_busy |-> (mul_start == '0));

endmodule

// File: rtl/iil_issue_unit.sv
module iil_issue_unit
  import iil_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int MUL_LAT = 3,
  localparam int RW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual_mode,
  input  logic          mul_block_all,
  input  logic          s0_valid,
  input  logic [2:0]    s0_cls,
  input  logic [RW-1:0] s0_dst,
  input  logic [RW-1:0] s0_srca,
  input  logic [RW-1:0] s0_srcb,
  input  logic          s1_valid,
  input  logic [2:0]    s1_cls,
  input  logic [RW-1:0] s1_dst,
  input  logic [RW-1:0] s1_srca,
  input  logic [RW-1:0] s1_srcb,
  output logic [1:0]    issue_valid,
  output logic          stall,
  output logic [2:0]    dep_vec
);

  logic                        rst_sn;
  logic [ISSUE_W-1:0]          v;
  iclass_e                     cls [ISSUE_W];
  logic [ISSUE_W-1:0][RW-1:0]  dst, sa, sb;
  logic [ISSUE_W-1:0]          haz;
  logic [ISSUE_W-1:0]          ld_v;
  logic [ISSUE_W-1:0][RW-1:0]  ld_dst;
  logic                        mul_busy;
  logic [RW-1:0]               mul_dst;
  logic [2:0]                  dep;
  logic [ISSUE_W-1:0]          iss;
  logic                        pair_ok;

  iil_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  assign v   = {s1_valid, s0_valid};
  assign dst = {s1_dst, s0_dst};
  assign sa  = {s1_srca, s0_srca};
  assign sb  = {s1_srcb, s0_srcb};
  assign cls[0] = iclass_e'(s0_cls);
  assign cls[1] = iclass_e'(s1_cls);

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_slot
    iil_slot_hazard #(.RW(RW), .NLD(ISSUE_W)) u_haz (
      .valid     (v[g]),
      .cls       (cls[g]),
      .dst       (dst[g]),
      .srca      (sa[g]),
      .srcb      (sb[g]),
      .ld_v      (ld_v),
      .ld_dst    (ld_dst),
      .mul_busy  (mul_busy),
      .mul_dst   (mul_dst),
      .block_all (mul_block_all),
      .hazard    (haz[g])
    );
  end

  iil_pair_dep #(.RW(RW)) u_pair (
    .v_old (v[0]),
    .d_old (dst[0]),
    .a_old (sa[0]),
    .b_old (sb[0]),
    .v_new (v[1]),
    .d_new (dst[1]),
    .a_new (sa[1]),
    .b_new (sb[1]),
    .dep   (dep)
  );

  // Issue decision: older first, younger only alongside it
  always_comb begin
    iss[0]  = v[0] && !haz[0];
    pair_ok = dual_mode && v[1] && !haz[1] && (dep == 3'b000) &&
              !((cls[0] == CL_MUL) && (cls[1] == CL_MUL));
    iss[1]  = iss[0] && pair_ok;
  end

  iil_scoreboard #(.RW(RW), .MUL_LAT(MUL_LAT)) u_sb (
    .clk      (clk),
    .rst_n    (rst_sn),
    .iss      (iss),
    .cls      (cls),
    .dst      (dst),
    .ld_v     (ld_v),
    .ld_dst   (ld_dst),
    .mul_busy (mul_busy),
    .mul_dst  (mul_dst)
  );

  assign issue_valid = iss;
  assign stall       = v[0] && !iss[0];
  assign dep_vec     = dep;

  p_pair_order_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    issue_valid[1] |-> issue_valid[0]);

  p_single_issue_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !dual_mode |-> !issue_valid[1]);

  p_dep_blocks_pair_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (dep_vec != 3'b000) |-> !issue_valid[1]);

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (mul_block_all && mul_busy) |-> (issue_valid == 2'b00));

  p_load_shadow_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (ld_v[0] && (ld_dst[0] != '0) && (s0_srca == ld_dst[0])) |-> !issue_valid[0]);

  p_r0_free_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (s0_valid && !mul_busy && (s0_dst == '0) && (s0_srca == '0) &&
     (s0_srcb == '0)) |-> issue_valid[0]);

endmodule

// File: tb/tb_iil_issue_unit.sv
`timescale 1ns/1ps
module tb_iil_issue_unit;

  localparam int RW  = 5;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dual_mode, mul_block_all;
  logic          s0_valid, s1_valid;
  logic [2:0]    s0_cls, s1_cls;
  logic [RW-1:0] s0_dst, s0_srca, s0_srcb, s1_dst, s1_srca, s1_srcb;
  logic [1:0]    issue_valid;
  logic          stall;
  logic [2:0]    dep_vec;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  iil_issue_unit #(.NREG(32), .MUL_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .mul_block_all(mul_block_all),
    .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_srca(s0_srca), .s0_srcb(s0_srcb),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_dst(s1_dst), .s1_srca(s1_srca), .s1_srcb(s1_srcb),
    .issue_valid(issue_valid), .stall(stall), .dep_vec(dep_vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic present(input logic v0, input int c0, input int d0, input int a0, input int b0,
                         input logic v1, input int c1, input int d1, input int a1, input int b1);
    @(negedge clk);
    s0_valid = v0; s0_cls = 3'(c0); s0_dst = RW'(d0); s0_srca = RW'(a0); s0_srcb = RW'(b0);
    s1_valid = v1; s1_cls = 3'(c1); s1_dst = RW'(d1); s1_srca = RW'(a1); s1_srcb = RW'(b1);
    #1;
  endtask

  task automatic one(input int c, input int d, input int a, input int b);
    present(1'b1, c, d, a, b, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) present(1'b0, 0, 0, 0, 0, 1'b0, 0, 0, 0, 0);
  endtask

  // Holds the present inputs and counts cycles until slot 0 issues
  task automatic count_stalls(output int n);
    n = 0;
    while (issue_valid[0] !== 1'b1 && n < 10) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [2:0] xdep(int d0, int a0, int b0, int d1, int a1, int b1);
    logic f, o, a;
    f = (d0 != 0) && ((a1 == d0) || (b1 == d0));
    o = (d0 != 0) && (d1 == d0);
    a = (d1 != 0) && ((d1 == a0) || (d1 == b0));
    return {f, o, a};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] e;
    rst_n = 1'b0; dual_mode = 1'b1; mul_block_all = 1'b0;
    s0_valid = 1'b0; s0_cls = '0; s0_dst = '0; s0_srca = '0; s0_srcb = '0;
    s1_valid = 1'b0; s1_cls = '0; s1_dst = '0; s1_srca = '0; s1_srcb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 / R11: first candidate issues, no stall; idle slot gives no stall
    check("R11 idle stall", stall, 0);
    check("R11 idle issue", issue_valid, 0);
    one(1, 1, 2, 3);
    check("R1 first issue", issue_valid, 1);
    check("R11 no stall", stall, 0);

    // R2: dependent ALU chain back to back
    one(1, 2, 1, 1);
    check("R2 alu chain a", issue_valid, 1);
    one(1, 3, 2, 2);
    check("R2 alu chain b", issue_valid, 1);

    // R6 / R7 / R8 / R9: sweep of every register triple over {0,1,2}
    for (int i = 0; i < 729; i++) begin
      int d0, a0, b0, d1, a1, b1;
      d0 = i % 3; a0 = (i / 3) % 3; b0 = (i / 9) % 3;
      d1 = (i / 27) % 3; a1 = (i / 81) % 3; b1 = (i / 243) % 3;
      present(1'b1, 1, d0, a0, b0, 1'b1, 1, d1, a1, b1);
      e = xdep(d0, a0, b0, d1, a1, b1);
      check("R6/R7 dep", dep_vec, e);
      check("R8/R9 pair", issue_valid, (e == 0) ? 3 : 1);
    end
    // R7: invalid slot 1 clears the vector
    present(1'b1, 1, 1, 0, 0, 1'b0, 1, 1, 1, 1);
    check("R7 invalid slot", dep_vec, 0);

    // R8: single mode never issues slot 1
    dual_mode = 1'b0;
    present(1'b1, 1, 4, 5, 6, 1'b1, 1, 7, 8, 9);
    check("R8 single mode", issue_valid, 1);
    dual_mode = 1'b1;

    // R3: load shadow
    idle(2);
    one(2, 4, 15, 0);
    check("R3 load issues", issue_valid, 1);
    one(1, 5, 4, 0);
    check("R3 shadow stall", issue_valid, 0);
    check("R11 stall flag", stall, 1);
    count_stalls(n);
    check("R3 shadow length", n, 1);
    one(2, 6, 15, 0);
    one(1, 7, 8, 0);
    check("R3 unrelated after load", issue_valid, 1);
    // load in slot 1, consumer next cycle in slot 0
    present(1'b1, 1, 9, 1, 1, 1'b1, 2, 10, 15, 0);
    check("R3 load paired", issue_valid, 3);
    one(1, 11, 0, 10);
    check("R3 slot1 load shadow", issue_valid, 0);
    count_stalls(n);
    check("R3 slot1 shadow length", n, 1);

    // R4: multiply latency for reader, writer and second multiply, mode 0
    for (int kind = 0; kind < 3; kind++) begin
      idle(4);
      one(5, 12, 1, 2);
      check("R4 mul issues", issue_valid, 1);
      case (kind)
        0: one(1, 13, 12, 0);
        1: one(1, 12, 3, 0);
        default: one(5, 14, 3, 4);
      endcase
      count_stalls(n);
      check("R4 mul stall cycles", n, LAT - 1);
    end

    // R5: unrelated instruction during multiply, both modes
    for (int m = 0; m < 2; m++) begin
      idle(4);
      mul_block_all = m[0];
      one(5, 12, 1, 2);
      one(1, 20, 21, 22);
      count_stalls(n);
      check("R5 unrelated during mul", n, (m == 1) ? LAT - 1 : 0);
    end
    mul_block_all = 1'b0;

    // R8: two multiplies cannot pair; the second then waits
    idle(4);
    present(1'b1, 5, 1, 2, 3, 1'b1, 5, 4, 5, 6);
    check("R8 mul pair", issue_valid, 1);
    present(1'b1, 5, 4, 5, 6, 1'b0, 0, 0, 0, 0);
    count_stalls(n);
    check("R8 second mul wait", n, LAT - 1);

    // R10: branch beside and before other instructions
    idle(4);
    present(1'b1, 4, 0, 1, 2, 1'b1, 1, 7, 3, 3);
    check("R10 branch pair", issue_valid, 3);
    dual_mode = 1'b0;
    one(4, 0, 7, 3);
    check("R10 branch single", issue_valid, 1);
    one(1, 8, 7, 0);
    check("R10 after branch", issue_valid, 1);
    dual_mode = 1'b1;
    present(1'b1, 4, 0, 1, 2, 1'b1, 1, 1, 3, 3);
    check("R10 branch anti", issue_valid, 1);

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule